// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

This block is one channel of an interval timer with a small register port. Software writes a start value into a down counter while the channel is stopped, picks a tick source and an 8-bit prescale ratio, and then starts the channel. The counter steps down once per prescaled tick. When it reaches zero it raises a sticky timeout flag, loads the start value again and keeps running. The flag can drive a level interrupt request, a level wake-up request, or both, through two separate enables. Software clears the flag by writing a one to it.

The tick source is either every bus clock cycle or a slow reference. The slow reference is a 32.768 kHz clock that has already been brought into the bus clock domain and arrives as a one-cycle enable pulse, `slow_tick`. The counter width is a parameter. It is 32 bits for a free-running time base and 16 bits for an event channel. Software may read the live count at any time. Because the count can change between accesses, software takes a count as valid only after two reads in a row return the same value.

Top module: `ivl_timer`

## Requirements
- R1: After reset every register reads zero, and `irq` and `wake` are low.
- R2: The register map is: address 0 control, address 1 prescale in bits [7:0], address 2 count. A write to address 2 while the run bit is clear sets both the live count and the reload value to the written data. Reading address 2 then returns that data.
- R3: A write to address 2 while the run bit (control bit 0) is set leaves the count unchanged.
- R4: The bus clock is the source when control bit 1 is clear. In that case the count steps down once every PRE+1 cycles, where PRE is the prescale value. A tick that arrives while the count is zero is an expiry, which sets the flag (control bit 4). Starting with count N at the enabling write, the flag sets (N+1)(PRE+1) cycles after that write.
- R5: On an expiry the counter loads the reload value and keeps counting while the run bit stays set. The next expiry follows after the same interval.
- R6: When control bit 1 is set, with PRE=0 the count steps down only on cycles where `slow_tick` is high. Bus cycles without a pulse leave it unchanged.
- R7: Writing control with bit 4 set clears the flag. Writing control with bit 4 clear leaves the flag as it was.
- R8: If an expiry happens in the same cycle as a write that clears the flag, the flag ends up set.
- R9: `irq` is high exactly while the flag and control bit 2 are both set. `wake` is high exactly while the flag and control bit 3 are both set.
- R10: Clearing the run bit stops counting and returns the prescale divider to zero. When the channel is enabled again, a full interval passes before the next expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle pulse per slow reference period, already in the bus clock domain |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Timeout interrupt request, level |
| wake | output | 1 | Timeout wake-up request, level |

## Verification
The assertions assume a single write port with one access per cycle. They also assume that `slow_tick` is a clean synchronous pulse, so a load, a clear and an expiry are the only events that can meet in one cycle. The stimulus always stops the channel before it loads a new count. It drives slow pulses only as isolated single cycles. It times the one clear that collides with an expiry exactly against the computed expiry cycle. Every other clear lands well away from an expiry, so each flag rise the monitor sees matches exactly one predicted cycle.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;

    localparam int BUS_W = 32;
    localparam int PRE_W = 8;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_PRE   = 2'd1;
    localparam logic [1:0] ADDR_COUNT = 2'd2;

    // Control word: flag at bit 4 down to run at bit 0.
    typedef struct packed {
        logic flag;
        logic wake_en;
        logic irq_en;
        logic slow_src;
        logic run;
    } ctrl_t;

    localparam int CTRL_W    = $bits(ctrl_t);
    localparam int FLAG_BIT  = CTRL_W - 1;

    function automatic logic [BUS_W-1:0] ctrl_word(input ctrl_t c);
        return BUS_W'(c);
    endfunction

endpackage

// File: rtl/ivl_tick_gen.sv
module ivl_tick_gen
    import ivl_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             slow_src,
    input  logic             slow_tick,
    input  logic [PRE_W-1:0] pre,
    output logic             tick
);
    logic [PRE_W-1:0] div_q;
    logic             src_ok;
    logic             hit;

    assign src_ok = slow_src ? slow_tick : 1'b1;
    assign hit    = (div_q == pre);
    assign tick   = run && src_ok && hit;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_q <= '0;
        end else if (src_ok) begin
            div_q <= hit ? '0 : div_q + 1'b1;
        end
    end
endmodule

// File: rtl/ivl_down_counter.sv
module ivl_down_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_q;

    assign expire = tick && (cnt_q == '0);
    assign cnt    = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            reload_q <= '0;
        end else if (load) begin
            cnt_q    <= load_val;
            reload_q <= load_val;
        end else if (expire) begin
            cnt_q    <= reload_q;
        end else if (tick) begin
            cnt_q    <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/ivl_ctrl_regs.sv
module ivl_ctrl_regs
    import ivl_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ctrl,
    input  logic             wr_pre,
    input  logic [PRE_W-1:0] wdata,
    input  logic             expire,
    output ctrl_t            ctrl,
    output logic [PRE_W-1:0] pre
);
    ctrl_t            ctrl_q;
    logic [PRE_W-1:0] pre_q;
    logic             clr_req;

    assign clr_req = wr_ctrl && wdata[FLAG_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            pre_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.run      <= wdata[0];
                ctrl_q.slow_src <= wdata[1];
                ctrl_q.irq_en   <= wdata[2];
                ctrl_q.wake_en  <= wdata[3];
            end
            // An expiry outranks a same-cycle clear.
            if (expire) begin
                ctrl_q.flag <= 1'b1;
            end else if (clr_req) begin
                ctrl_q.flag <= 1'b0;
            end
            if (wr_pre) begin
                pre_q <= wdata;
            end
        end
    end

    assign ctrl = ctrl_q;
    assign pre  = pre_q;
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
    import ivl_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slow_tick,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             irq,
    output logic             wake
);
    ctrl_t            ctrl;
    logic [PRE_W-1:0] pre;
    logic [CNT_W-1:0] cnt;
    logic             tick;
    logic             expire;
    logic             run_w;
    logic             flag_w;
    logic             wr_ctrl;
    logic             wr_pre;
    logic             load;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_pre  = bus_wr && (bus_addr == ADDR_PRE);
    assign load    = bus_wr && (bus_addr == ADDR_COUNT) && !ctrl.run;
    assign run_w   = ctrl.run;
    assign flag_w  = ctrl.flag;

    generate
        if (CNT_W < BUS_W) begin : g_unused_hi
            logic unused_wdata_hi;
            assign unused_wdata_hi = ^bus_wdata[BUS_W-1:CNT_W];
        end
    endgenerate

    ivl_ctrl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (wr_ctrl),
        .wr_pre  (wr_pre),
        .wdata   (bus_wdata[PRE_W-1:0]),
        .expire  (expire),
        .ctrl    (ctrl),
        .pre     (pre)
    );

    ivl_tick_gen u_tick (
        .clk       (clk),
        .rst       (rst),
        .run       (ctrl.run),
        .slow_src  (ctrl.slow_src),
        .slow_tick (slow_tick),
        .pre       (pre),
        .tick      (tick)
    );

    ivl_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (load),
        .load_val (bus_wdata[CNT_W-1:0]),
        .cnt      (cnt),
        .expire   (expire)
    );

    always_comb begin
        case (bus_addr)
            ADDR_CTRL:  bus_rdata = ctrl_word(ctrl);
            ADDR_PRE:   bus_rdata = BUS_W'(pre);
            ADDR_COUNT: bus_rdata = BUS_W'(cnt);
            default:    bus_rdata = '0;
        endcase
    end

    assign irq  = ctrl.flag && ctrl.irq_en;
    assign wake = ctrl.flag && ctrl.wake_en;
endmodule

// File: rtl/ivl_timer_checker.sv
module ivl_timer_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic             irq,
    input logic             wake,
    input logic             run,
    input logic             flag,
    input logic             expire,
    input logic [CNT_W-1:0] cnt
);
    logic wr_cnt;
    logic wr_clr;
    assign wr_cnt = bus_wr && (bus_addr == 2'd2);
    assign wr_clr = bus_wr && (bus_addr == 2'd0) && bus_wdata[4];

    assert_load_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_cnt && !run) |=> (cnt == $past(bus_wdata[CNT_W-1:0])));

    assert_busy_load_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_cnt && run && !expire) |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1));

    assert_flag_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_clr && !expire) |=> !flag);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (flag && !wr_clr) |=> flag);

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        expire |=> flag);

    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (irq || wake) |-> flag);

    assert_idle_no_expiry_R10: assert property (@(posedge clk) disable iff (rst)
        !run |-> !expire);

    assert_idle_count_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_cnt) |=> $stable(cnt));
endmodule

bind ivl_timer ivl_timer_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .wake      (wake),
    .run       (run_w),
    .flag      (flag_w),
    .expire    (expire),
    .cnt       (cnt)
);

// File: tb/ivl_timer_bench.sv
module ivl_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slow_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        wake;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int expq[$];
    logic irq_prev = 1'b0;
    bit done = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ivl_timer u_ivl_timer (
        .clk(clk), .rst(rst), .slow_tick(slow_tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .wake(wake)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse_slow();
        @(negedge clk); slow_tick = 1'b1;
        @(negedge clk); slow_tick = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: every rising irq must match the next predicted cycle.
    always @(negedge clk) begin
        if (!rst) begin
            if (irq && !irq_prev) begin
                checks++;
                if (expq.size() == 0) begin
                    fails++;
                    $display("FAIL R4: actual irq rise at %0d expected none", cyc);
                end else begin
                    int e;
                    e = expq.pop_front();
                    if (e != cyc) begin
                        fails++;
                        $display("FAIL R4/R5: actual irq rise at %0d expected %0d", cyc, e);
                    end
                end
            end
            irq_prev = irq;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int x;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        bus_read(2'd0, rd); check("R1 ctrl", rd, 0);
        bus_read(2'd1, rd); check("R1 pre", rd, 0);
        bus_read(2'd2, rd); check("R1 count", rd, 0);
        check("R1 irq", irq, 0);
        check("R1 wake", wake, 0);

        // R2 load while stopped
        bus_write(2'd2, 32'h1234);
        bus_read(2'd2, rd); check("R2 count readback", rd, 32'h1234);

        // R4/R5 bus-clock source, PRE=2, N=3, irq enabled
        bus_write(2'd1, 2);
        bus_write(2'd2, 3);
        bus_write(2'd0, 32'h05);
        x = cyc;
        expq.push_back(x + 12);
        expq.push_back(x + 24);
        while (!irq) @(negedge clk);
        check("R9 wake off", wake, 0);
        bus_write(2'd0, 32'h15);
        bus_read(2'd0, rd); check("R7 W1C clears", rd[4], 0);
        check("R9 irq follows flag", irq, 0);
        while (!irq) @(negedge clk);
        bus_write(2'd0, 32'h00);
        bus_read(2'd0, rd); check("R7 W0 keeps flag", rd, 32'h10);
        check("R9 irq gated", irq, 0);
        bus_write(2'd0, 32'h08);
        check("R9 wake on", wake, 1);
        bus_write(2'd0, 32'h18);
        bus_read(2'd0, rd); check("R7 clear with wake", rd, 32'h08);
        check("R9 wake off after clear", wake, 0);
        bus_write(2'd0, 32'h00);

        // R10 divider reset, then R8 collision
        bus_write(2'd1, 5);
        bus_write(2'd2, 0);
        bus_write(2'd0, 32'h05);
        repeat (3) @(negedge clk);
        bus_write(2'd0, 32'h04);
        bus_write(2'd0, 32'h05);
        x = cyc;
        expq.push_back(x + 6);
        while (cyc != x + 11) @(negedge clk);
        bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 32'h15;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_read(2'd0, rd); check("R8 set wins", rd[4], 1);
        bus_write(2'd0, 32'h10);
        bus_read(2'd0, rd); check("R7 final clear", rd, 0);

        // R6 slow source, R3 busy load ignored
        bus_write(2'd1, 0);
        bus_write(2'd2, 5);
        bus_write(2'd0, 32'h03);
        repeat (10) @(negedge clk);
        bus_read(2'd2, rd); check("R6 no pulse no step", rd, 5);
        bus_write(2'd2, 9);
        bus_read(2'd2, rd); check("R3 busy load ignored", rd, 5);
        pulse_slow(); pulse_slow(); pulse_slow();
        bus_read(2'd2, rd); check("R6 three pulses", rd, 2);
        bus_write(2'd0, 32'h00);

        repeat (4) @(negedge clk);
        check("R4 all predicted expiries seen", expq.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule